// File: doc/BRIEF.md
# Ancillary Packet Capture Buffer

The block receives decoded ancillary data packets from a video receiver as a byte stream and keeps the packets of the current vertical blanking interval in an internal RAM. Each packet arrives framed by start and end strobes, with its bytes in stream order: data ID, secondary data ID, data count, then the user words. The RAM is 16 bits wide, and every word holds two consecutive bytes. When a blanking interval begins, writing starts again at address zero. Packets go in one after another, and a 0xFF terminator byte follows the last stored packet.

A packet is committed only if all its bytes and the terminator fit in the RAM. A packet that does not fit is rolled back, so the terminator ends up where it was before that packet. Every later packet in the same interval is then dropped. When blanking ends, a sticky interrupt flag tells the host to read the RAM through a synchronous read port before the next interval overwrites it. A count of the packets committed in the current interval is also presented.

Top module: `anc_cap_buf`

## Requirements
- R1: Accepted packet bytes are stored at consecutive byte addresses in arrival order, starting at byte address 0 in each blanking interval. Byte address b is held in RAM word b/2. Even b uses bits 15:8 and odd b uses bits 7:0.
- R2: After each committed packet, byte 0xFF is written at the next byte address. If that address is even, bits 7:0 of the same word are also set to 0xFF.
- R3: A packet of N bytes that starts at byte address B is committed only if B+N+1 <= 2*DEPTH. Otherwise the RAM is left with the terminator at B, as if the packet had never started.
- R4: After a packet has been discarded for lack of space, every further packet in the same blanking interval is discarded, even one that would fit.
- R5: irq_o rises in the cycle after vblank_i falls and stays high until irq_clr_i is sampled high. A falling edge of vblank_i in the same cycle as irq_clr_i takes priority.
- R6: pkt_count_o reads 0 after each rising edge of vblank_i and increases by one for each committed packet.
- R7: Bytes are ignored in these cases: vblank_i is low; the byte arrives in the first cycle of blanking; or the byte has no start strobe and no packet is open.
- R8: If vblank_i falls while a packet is still open, that packet is discarded and the terminator is restored at its start address.
- R9: rd_data_o presents the RAM word at rd_addr_i one clock after the address is sampled.
- R10: After reset, irq_o is 0 and pkt_count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vblank_i | input | 1 | High during the vertical blanking interval |
| anc_valid_i | input | 1 | A packet byte is present this cycle |
| anc_sop_i | input | 1 | First byte of a packet (data ID) |
| anc_eop_i | input | 1 | Last byte of a packet |
| anc_byte_i | input | 8 | Packet byte |
| rd_addr_i | input | $clog2(DEPTH) | Host read word address |
| rd_data_o | output | 16 | Host read data, lower byte address in bits 15:8 |
| irq_clr_i | input | 1 | Write-one pulse that clears the interrupt |
| irq_o | output | 1 | Sticky end-of-field interrupt |
| pkt_count_o | output | $clog2(2*DEPTH)+1 | Packets committed in the current interval |

## Verification
The assertions check the interrupt flag on every cycle: it is set by the end of blanking, it holds, and it clears with priority given to the set. They also check that the packet count clears at the start of blanking, never steps by more than one, and stays frozen outside blanking. Only the bench scenarios can show byte placement and lane packing, the terminator, the exact-fit boundary, rollback after an oversized packet, the drop of later packets, and the discard when blanking ends in mid-packet. The bench shows these by reading back RAM words through the host port.

// File: rtl/anc_cap_pkg.sv
package anc_cap_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t TERM_BYTE = 8'hFF;

  // one RAM word write, per-lane enables
  typedef struct packed {
    logic  hi_we;
    logic  lo_we;
    byte_t hi_d;
    byte_t lo_d;
  } lane_wr_t;
endpackage

// File: rtl/anc_edge_det.sv
module anc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/anc_irq_flag.sv
module anc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/anc_byte_ram.sv
module anc_byte_ram
  import anc_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic [AW-1:0]   waddr_i,
  input  lane_wr_t        wr_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [2*BYTE_W-1:0] rdata_o
);
  logic [1:0] lane_we;
  byte_t      lane_wd [2];
  byte_t      lane_rd [2];

  // lane 1 = bits 15:8 (even byte address), lane 0 = bits 7:0
  assign lane_we[1] = wr_i.hi_we;
  assign lane_we[0] = wr_i.lo_we;
  assign lane_wd[1] = wr_i.hi_d;
  assign lane_wd[0] = wr_i.lo_d;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    byte_t mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (lane_we[g]) mem[waddr_i] <= lane_wd[g];
      lane_rd[g] <= mem[raddr_i];
    end
  end

  assign rdata_o = {lane_rd[1], lane_rd[0]};
endmodule

// File: rtl/anc_wr_ctrl.sv
module anc_wr_ctrl
  import anc_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(2*DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vblank_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          valid_i,
  input  logic          sop_i,
  input  logic          eop_i,
  input  byte_t         byte_i,
  output logic [AW-1:0] waddr_o,
  output lane_wr_t      wr_o,
  output logic [PW-1:0] count_o
);
  localparam logic [PW:0] CAP = (PW+1)'(2*DEPTH);

  logic [PW-1:0] base_q, ptr_q, cnt_q;
  logic          in_pkt_q, drop_q, term_q;

  logic          acc, start, cont, take, fits, room;
  logic          do_wr, commit, abort, grow;
  logic [PW-1:0] at;
  logic [PW:0]   at_x, nxt_x;

  always_comb begin
    acc    = valid_i & vblank_i & ~rise_i & ~drop_q;
    start  = acc & sop_i;
    cont   = acc & ~sop_i & in_pkt_q;
    take   = start | cont;
    at     = start ? base_q : ptr_q;   // a new start always rewinds to the commit point
    at_x   = {1'b0, at};
    nxt_x  = at_x + 1'b1;
    fits   = at_x < CAP;
    room   = nxt_x < CAP;              // terminator slot after the last byte
    do_wr  = take & fits;
    commit = do_wr & eop_i & room;
    abort  = take & (~fits | (eop_i & ~room));
    grow   = do_wr & ~eop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      term_q   <= 1'b0;
    end else if (rise_i) begin
      base_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      term_q   <= 1'b1;
    end else if (abort) begin
      drop_q   <= 1'b1;
      in_pkt_q <= 1'b0;
      term_q   <= 1'b1;
    end else if (commit) begin
      base_q   <= nxt_x[PW-1:0];
      ptr_q    <= nxt_x[PW-1:0];
      cnt_q    <= cnt_q + 1'b1;
      in_pkt_q <= 1'b0;
      term_q   <= 1'b1;
    end else if (grow) begin
      ptr_q    <= nxt_x[PW-1:0];
      in_pkt_q <= 1'b1;
      term_q   <= 1'b0;
    end else if (fall_i && in_pkt_q) begin
      in_pkt_q <= 1'b0;
      term_q   <= 1'b1;
    end
  end

  // data byte wins the port; a pending terminator is re-armed by the packet's outcome
  always_comb begin
    wr_o    = '0;
    waddr_o = base_q[AW:1];
    if (do_wr) begin
      waddr_o = at[AW:1];
      if (at[0]) begin
        wr_o.lo_we = 1'b1;
        wr_o.lo_d  = byte_i;
      end else begin
        wr_o.hi_we = 1'b1;
        wr_o.hi_d  = byte_i;
      end
    end else if (term_q) begin
      wr_o.lo_we = 1'b1;
      wr_o.lo_d  = TERM_BYTE;
      wr_o.hi_we = ~base_q[0];
      wr_o.hi_d  = TERM_BYTE;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/anc_cap_buf.sv
module anc_cap_buf
  import anc_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(2*DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vblank_i,
  input  logic          anc_valid_i,
  input  logic          anc_sop_i,
  input  logic          anc_eop_i,
  input  logic [7:0]    anc_byte_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [15:0]   rd_data_o,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic [PW-1:0] pkt_count_o
);
  logic          vb_rise, vb_fall;
  logic [AW-1:0] waddr;
  lane_wr_t      wr;

  anc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (vblank_i),
    .rise_o (vb_rise),
    .fall_o (vb_fall)
  );

  anc_wr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vblank_i (vblank_i),
    .rise_i   (vb_rise),
    .fall_i   (vb_fall),
    .valid_i  (anc_valid_i),
    .sop_i    (anc_sop_i),
    .eop_i    (anc_eop_i),
    .byte_i   (anc_byte_i),
    .waddr_o  (waddr),
    .wr_o     (wr),
    .count_o  (pkt_count_o)
  );

  anc_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .waddr_i (waddr),
    .wr_i    (wr),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  anc_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (vb_fall),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/anc_cap_buf_chk.sv
module anc_cap_buf_chk #(
  parameter int PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vblank_i,
  input logic          irq_clr_i,
  input logic          irq_o,
  input logic [PW-1:0] pkt_count_o
);
  a_r5_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vblank_i) |=> irq_o);

  a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r5_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !$fell(vblank_i)) |=> !irq_o);

  a_r6_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vblank_i) |=> (pkt_count_o == '0));

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(vblank_i) |=> (pkt_count_o == $past(pkt_count_o) ||
                          pkt_count_o == $past(pkt_count_o) + 1'b1));

  a_r7_count_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(pkt_count_o));
endmodule

bind anc_cap_buf anc_cap_buf_chk #(.PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vblank_i    (vblank_i),
  .irq_clr_i   (irq_clr_i),
  .irq_o       (irq_o),
  .pkt_count_o (pkt_count_o)
);

// File: tb/anc_cap_buf_test.sv
`timescale 1ns/1ps
module anc_cap_buf_test;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(2*DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vblank_i = 1'b0;
  logic          anc_valid_i = 1'b0;
  logic          anc_sop_i = 1'b0;
  logic          anc_eop_i = 1'b0;
  logic [7:0]    anc_byte_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [15:0]   rd_data_o;
  logic          irq_clr_i = 1'b0;
  logic          irq_o;
  logic [PW-1:0] pkt_count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  anc_cap_buf #(.DEPTH(DEPTH)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .vblank_i    (vblank_i),
    .anc_valid_i (anc_valid_i),
    .anc_sop_i   (anc_sop_i),
    .anc_eop_i   (anc_eop_i),
    .anc_byte_i  (anc_byte_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .irq_clr_i   (irq_clr_i),
    .irq_o       (irq_o),
    .pkt_count_o (pkt_count_o)
  );

  // period B readback: {word address, expected word}
  localparam logic [AW+15:0] B_TAB [8] = '{
    {3'd0, 16'hA1B2}, {3'd1, 16'h01C3}, {3'd2, 16'hD0D1}, {3'd3, 16'h0880},
    {3'd4, 16'h8182}, {3'd5, 16'h8384}, {3'd6, 16'h8586}, {3'd7, 16'h87FF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    anc_valid_i = 1'b1; anc_sop_i = s; anc_eop_i = e; anc_byte_i = b;
    @(negedge clk);
    anc_valid_i = 1'b0; anc_sop_i = 1'b0; anc_eop_i = 1'b0;
  endtask

  // header did, sdid, count dc, then dc words first, first+1, ...; whole = 0 leaves it open
  task automatic pkt(input logic [7:0] did, input logic [7:0] sdid, input int dc,
                     input logic [7:0] first, input bit whole);
    put(did, 1'b1, 1'b0);
    put(sdid, 1'b0, 1'b0);
    put(8'(dc), 1'b0, whole && dc == 0);
    for (int i = 0; i < dc; i++) put(first + 8'(i), 1'b0, whole && i == dc - 1);
  endtask

  task automatic vb(input logic v);
    @(negedge clk);
    vblank_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    rd_addr_i = AW'(a);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 irq", irq_o, 0);
    check("R10 count", pkt_count_o, 0);

    // period A: two packets, odd terminator position
    vb(1'b1);
    pkt(8'h41, 8'h05, 2, 8'h11, 1'b1);
    pkt(8'h60, 8'h60, 1, 8'h33, 1'b1);
    @(negedge clk);
    check("R6 count A", pkt_count_o, 2);
    vb(1'b0);
    check("R5 irq set", irq_o, 1);
    rd(0, d); check("R1 w0 A / R9", d, 16'h4105);
    rd(2, d); check("R1 w2 A", d, 16'h1260);
    rd(3, d); check("R1 w3 A", d, 16'h6001);
    rd(4, d); check("R2 odd terminator", d, 16'h33FF);
    // outside blanking: ignored
    pkt(8'h99, 8'h98, 1, 8'h97, 1'b1);
    @(negedge clk);
    check("R7 count idle", pkt_count_o, 2);
    rd(0, d); check("R7 w0 kept", d, 16'h4105);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    check("R5 irq cleared", irq_o, 0);
    repeat (3) @(negedge clk);
    check("R5 irq stays clear", irq_o, 0);

    // period B: stray byte, exact fit, then a packet that crosses the end
    vb(1'b1);
    check("R6 count cleared", pkt_count_o, 0);
    put(8'h55, 1'b0, 1'b0);
    pkt(8'hA1, 8'hB2, 1, 8'hC3, 1'b1);
    pkt(8'hD0, 8'hD1, 8, 8'h80, 1'b1);
    pkt(8'h90, 8'h91, 1, 8'h92, 1'b1);
    @(negedge clk);
    check("R3 count B", pkt_count_o, 2);
    vb(1'b0);
    for (int i = 0; i < 8; i++) begin
      rd(int'(B_TAB[i][AW+15:16]), d);
      check("R1/R3 table B", d, B_TAB[i][15:0]);
    end

    // period C: oversized first packet, then one that would fit
    vb(1'b1);
    check("R5 irq held", irq_o, 1);
    pkt(8'h10, 8'h20, 17, 8'h00, 1'b1);
    pkt(8'h70, 8'h71, 0, 8'h00, 1'b1);
    @(negedge clk);
    check("R4 count C", pkt_count_o, 0);
    vb(1'b0);
    rd(0, d); check("R4 rollback w0", d, 16'hFFFF);

    // period D: commit, then blanking ends mid-packet
    vb(1'b1);
    pkt(8'hE1, 8'hE2, 1, 8'hE3, 1'b1);
    put(8'hF1, 1'b1, 1'b0);
    put(8'hF2, 1'b0, 1'b0);
    vb(1'b0);
    check("R8 count D", pkt_count_o, 1);
    rd(0, d); check("R4 restart w0", d, 16'hE1E2);
    rd(1, d); check("R1 w1 D", d, 16'h01E3);
    rd(2, d); check("R8 partial removed", d, 16'hFFFF);

    finish_run();
  end
endmodule